// File: doc/BRIEF.md
# Phase-Cut Dimmer Type Classifier

This controller decides how the AC line feeding a lamp driver is being phase-cut and sets the driver's operating mode to one of no-dimmer, leading-edge or trailing-edge. It does not sense the line itself. Upstream analog and sampling logic hands it one set of observations per half-cycle: a boundary strobe, a flag saying the half-cycle was phase-cut, a flag saying the cut was at the leading edge, and a flag saying the voltage fell steeply at the end of conduction.

Once the supply is good, the block spends a fixed number of half-cycles learning. During that time it drives the leading-edge mode. It then commits a verdict by majority vote and moves to a validate phase. In the validate phase it looks at one half-cycle out of every interval and compares it with the committed mode. Each comparison moves a saturating up/down counter, which acts as a low-pass filter on the verdicts. When that counter reaches its threshold, the block goes back to learning. If the supply drops at any time, the block goes idle.

Top module: `dimmer_classifier`

## Requirements
- R1: While reset is held, and in the first cycle after it, `phase` reads idle (0) and `mode` reads no-dimmer (0).
- R2: In idle with `pwr_ok` high, the next cycle enters learn (`phase`=1). A low `pwr_ok` in any cycle puts `phase`=0 and `mode`=0 in the next cycle. This takes precedence over every other transition, and strobes seen while idle have no effect.
- R3: Throughout the learn phase, `mode` reads leading-edge (1).
- R4: Each half-cycle is classified as follows. With `cut` low, it is no-dimmer. With `cut` high, `steep` high and `lead` low, it is trailing-edge (2). Any other half-cycle with `cut` high is leading-edge. Mode value 3 and phase value 3 never appear.
- R5: The learn phase ends on its LEARN_HC-th strobe (default 4, two line cycles). At the clock edge that samples that strobe, `phase` becomes validate (2) and the verdict appears on `mode`. Earlier strobes leave the phase at learn.
- R6: The learn verdict is taken from the strobes of the learn window. If more than half of them were phase-cut, the verdict is trailing-edge when trailing votes strictly outnumber leading votes, and leading-edge otherwise. If half or fewer were phase-cut, the verdict is no-dimmer.
- R7: In validate, only every CHECK_HC-th strobe (default 16), counted from entry to validate, is compared with `mode`. Other strobes, and cycles without a strobe, change neither phase nor mode.
- R8: Each compared strobe moves the filter counter: up by one on a mismatch, down by one on a match. The counter does not go below zero.
- R9: When the filter counter reaches FILT_TH (default 4), the block returns to learn with leading-edge mode. Both the filter counter and the interval count restart from zero after every phase change.
- R10: While the block stays in validate, `mode` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply above its start threshold |
| hc_tick | input | 1 | One-cycle strobe at each half-cycle boundary |
| cut | input | 1 | The half-cycle just ended was phase-cut |
| lead | input | 1 | The cut was at the leading edge |
| steep | input | 1 | Steep falling slope at the end of conduction |
| phase | output | 2 | 0 idle, 1 learn, 2 validate |
| mode | output | 2 | 0 no-dimmer, 1 leading-edge, 2 trailing-edge |

## Verification
The supply-loss path can land in the same cycle as a phase-ending strobe. One case is the final learn strobe. The other is the compared validate strobe that would bring the filter to its threshold. The bench provokes each by lowering `pwr_ok` in exactly the cycle that carries that strobe. It judges the outcome in two steps. First, the next cycle must show idle with no-dimmer rather than validate or learn. Second, after a restart, a fresh learn window must take its full length, and the filter must again need its full count of mismatches, which shows that no partial count survived the collision.

// File: rtl/dimcls_pkg.sv
// Shared types for the dimmer classifier.
// It holds the phase and mode encodings and the classification rule for one half-cycle.
package dimcls_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_LEAD  = 2'd1,
        MODE_TRAIL = 2'd2
    } mode_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEARN = 2'd1,
        PH_VALID = 2'd2
    } phase_t;

    // Classify one half-cycle.
    // A leading-edge signature overrides the slope flag.
    function automatic mode_t classify(input logic cut_i, input logic lead_i, input logic steep_i);
        if (!cut_i)
            return MODE_NONE;
        else if (steep_i && !lead_i)
            return MODE_TRAIL;
        else
            return MODE_LEAD;
    endfunction

endpackage

// File: rtl/dimcls_learn.sv
// Learn-window vote accumulator.
// It counts the strobes of one learn window and the leading and trailing votes among them.
// On the last strobe it raises done and offers the majority verdict, with that strobe included.
// Assumes: tick is already qualified to the learn phase; clr holds the counts at zero outside learn.
module dimcls_learn
    import dimcls_pkg::*;
#(
    parameter int LEARN_HC = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  tick,
    input  mode_t obs,
    output logic  done,
    output mode_t verdict
);
    localparam int CW = $clog2(LEARN_HC + 1);

    logic [CW-1:0] seen_q, lead_q, trail_q;
    logic [CW-1:0] lead_nx, trail_nx;
    logic [CW:0]   cut_total;

    // Vote totals including the strobe of this cycle.
    always_comb begin
        lead_nx   = lead_q  + CW'(obs == MODE_LEAD);
        trail_nx  = trail_q + CW'(obs == MODE_TRAIL);
        cut_total = {1'b0, lead_nx} + {1'b0, trail_nx};
    end

    assign done = tick && (seen_q == CW'(LEARN_HC - 1));

    // Majority decision on the whole window.
    always_comb begin
        if (2 * int'(cut_total) > LEARN_HC)
            verdict = (trail_nx > lead_nx) ? MODE_TRAIL : MODE_LEAD;
        else
            verdict = MODE_NONE;
    end

    // Window counters: cleared outside learn and at completion, advanced per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || done) begin
            seen_q  <= '0;
            lead_q  <= '0;
            trail_q <= '0;
        end else if (tick) begin
            seen_q  <= seen_q + 1'b1;
            lead_q  <= lead_nx;
            trail_q <= trail_nx;
        end
    end

endmodule

// File: rtl/dimcls_filter.sv
// Periodic re-check with a low-pass verdict filter.
// It counts the strobes of each interval and compares the last one with the active mode.
// A saturating up/down counter filters the comparisons, and relearn is raised on the
// compare that would bring the counter to FILT_TH.
// Assumes: CHECK_HC >= 2 and FILT_TH >= 1; clr is held outside the validate phase.
module dimcls_filter
    import dimcls_pkg::*;
#(
    parameter int CHECK_HC = 16,
    parameter int FILT_TH  = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  tick,
    input  mode_t obs,
    input  mode_t cur,
    output logic  relearn
);
    localparam int IW = $clog2(CHECK_HC);
    localparam int FW = $clog2(FILT_TH + 1);

    logic [IW-1:0] iv_q;
    logic [FW-1:0] flt_q;
    logic          check, mismatch;

    assign check    = tick && (iv_q == IW'(CHECK_HC - 1));
    assign mismatch = (obs != cur);
    assign relearn  = check && mismatch && (flt_q == FW'(FILT_TH - 1));

    // Interval counter and filter counter; both restart on clear or relearn.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || relearn) begin
            iv_q  <= '0;
            flt_q <= '0;
        end else if (tick) begin
            iv_q <= check ? '0 : iv_q + 1'b1;
            if (check) begin
                if (mismatch)
                    flt_q <= flt_q + 1'b1;
                else if (flt_q != '0)
                    flt_q <= flt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dimmer_classifier.sv
// Top level of the phase-cut dimmer classifier.
// It sequences idle, learn and validate, and owns the mode register.
// Assumes: hc_tick is a one-cycle strobe, and cut, lead and steep are valid in the strobe cycle.
module dimmer_classifier
    import dimcls_pkg::*;
#(
    parameter int LEARN_HC = 4,
    parameter int CHECK_HC = 16,
    parameter int FILT_TH  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       hc_tick,
    input  logic       cut,
    input  logic       lead,
    input  logic       steep,
    output logic [1:0] phase,
    output logic [1:0] mode
);
    phase_t phase_q, phase_d;
    mode_t  mode_q, mode_d;
    mode_t  obs, verdict;
    logic   learn_done, relearn;

    assign obs = classify(cut, lead, steep);

    dimcls_learn #(.LEARN_HC(LEARN_HC)) u_learn (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_q != PH_LEARN),
        .tick    (hc_tick && phase_q == PH_LEARN),
        .obs     (obs),
        .done    (learn_done),
        .verdict (verdict)
    );

    dimcls_filter #(.CHECK_HC(CHECK_HC), .FILT_TH(FILT_TH)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_q != PH_VALID),
        .tick    (hc_tick && phase_q == PH_VALID),
        .obs     (obs),
        .cur     (mode_q),
        .relearn (relearn)
    );

    // Next phase and mode; loss of supply overrides every transition.
    always_comb begin
        phase_d = phase_q;
        mode_d  = mode_q;
        if (!pwr_ok) begin
            phase_d = PH_IDLE;
            mode_d  = MODE_NONE;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    phase_d = PH_LEARN;
                    mode_d  = MODE_LEAD;
                end
                PH_LEARN: if (learn_done) begin
                    phase_d = PH_VALID;
                    mode_d  = verdict;
                end
                PH_VALID: if (relearn) begin
                    phase_d = PH_LEARN;
                    mode_d  = MODE_LEAD;
                end
                default: begin
                    phase_d = PH_IDLE;
                    mode_d  = MODE_NONE;
                end
            endcase
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            mode_q  <= MODE_NONE;
        end else begin
            phase_q <= phase_d;
            mode_q  <= mode_d;
        end
    end

    assign phase = phase_q;
    assign mode  = mode_q;

endmodule

// File: rtl/dimcls_chk.sv
// Property checker for dimmer_classifier.
// It watches only the ports and is attached to the top module with bind.
module dimcls_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_ok,
    input logic       hc_tick,
    input logic [1:0] phase,
    input logic [1:0] mode
);
    p_supply_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (phase == 2'd0 && mode == 2'd0));

    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0 && pwr_ok) |=> (phase == 2'd1));

    p_learn_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1) |-> (mode == 2'd1));

    p_legal_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'd3 && mode != 2'd3));

    p_enter_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && $past(phase) != 2'd2) |-> ($past(phase) == 2'd1 && $past(hc_tick)));

    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && !hc_tick && phase != 2'd0) |=> $stable(phase));

    p_relearn_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && $past(phase) == 2'd2) |-> ($past(hc_tick) && $past(pwr_ok)));

    p_mode_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |=> (phase != 2'd2 || $stable(mode)));

endmodule

bind dimmer_classifier dimcls_chk u_dimcls_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_ok  (pwr_ok),
    .hc_tick (hc_tick),
    .phase   (phase),
    .mode    (mode)
);

// File: tb/test_dimmer_classifier.sv
// Directed bench for dimmer_classifier, with one task per scenario.
module test_dimmer_classifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       hc_tick = 1'b0;
    logic       cut = 1'b0;
    logic       lead = 1'b0;
    logic       steep = 1'b0;
    logic [1:0] phase;
    logic [1:0] mode;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [1:0] IDL = 2'd0, LRN = 2'd1, VAL = 2'd2;
    localparam logic [1:0] NON = 2'd0, LED = 2'd1, TRL = 2'd2;

    always #2.5 clk = ~clk;

    dimmer_classifier i_dimmer_classifier (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .hc_tick(hc_tick),
        .cut(cut), .lead(lead), .steep(steep), .phase(phase), .mode(mode)
    );

    // Compare phase and mode with the expected pair.
    task automatic expect_st(input string req, input logic [1:0] eph, input logic [1:0] emd);
        total++;
        if (phase !== eph || mode !== emd) begin
            bad++;
            $display("FAIL %s: phase=%0d mode=%0d expected phase=%0d mode=%0d",
                     req, phase, mode, eph, emd);
        end
    endtask

    // One half-cycle strobe, driven from a negedge and ending at the next negedge.
    task automatic hc(input logic c, input logic l, input logic s, input logic pw);
        hc_tick = 1'b1; cut = c; lead = l; steep = s; pwr_ok = pw;
        @(negedge clk);
        hc_tick = 1'b0; cut = 1'b0; lead = 1'b0; steep = 1'b0;
    endtask

    // Drop the supply for one cycle, then raise it and enter learn.
    task automatic restart();
        pwr_ok = 1'b0;
        @(negedge clk);
        expect_st("R2 supply drop", IDL, NON);
        pwr_ok = 1'b1;
        @(negedge clk);
        expect_st("R3 learn entry", LRN, LED);
    endtask

    // Run a four-strobe learn window; bit i of each vector belongs to strobe i.
    task automatic t_learn(input logic [3:0] c, input logic [3:0] l, input logic [3:0] s,
                           input logic [1:0] emd, input string req);
        for (int i = 0; i < 4; i++) begin
            hc(c[i], l[i], s[i], 1'b1);
            if (i == 2) expect_st("R5 still learning", LRN, LED);
        end
        expect_st(req, VAL, emd);
    endtask

    // One validate interval with LEAD active: 15 filler strobes, then the compared strobe.
    // The filler carries the opposite verdict, so it would show if it were counted.
    task automatic t_vcheck(input logic mis, input logic drop, input logic [1:0] eph,
                            input logic [1:0] emd, input string req);
        for (int i = 0; i < 15; i++) begin
            if (mis) hc(1'b1, 1'b1, 1'b0, 1'b1);
            else     hc(1'b0, 1'b0, 1'b0, 1'b1);
        end
        expect_st("R7 filler ignored", VAL, LED);
        if (mis) hc(1'b0, 1'b0, 1'b0, !drop);
        else     hc(1'b1, 1'b1, 1'b0, !drop);
        expect_st(req, eph, emd);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_st("R1 in reset", IDL, NON);
        rst_n = 1'b1;
        @(negedge clk);
        expect_st("R1 after reset", IDL, NON);
        hc(1'b1, 1'b1, 1'b0, 1'b0);
        expect_st("R2 strobe while idle", IDL, NON);
        pwr_ok = 1'b1;
        @(negedge clk);
        expect_st("R2 start on supply", LRN, LED);
    endtask

    task automatic t_learn_patterns();
        t_learn(4'b0000, 4'b0000, 4'b0000, NON, "R6 no cut");
        restart();
        t_learn(4'b1111, 4'b1111, 4'b0000, LED, "R6 all leading");
        restart();
        t_learn(4'b1111, 4'b0000, 4'b1111, TRL, "R4 steep trailing");
        restart();
        t_learn(4'b1111, 4'b1111, 4'b1111, LED, "R4 lead overrides slope");
        restart();
        t_learn(4'b0111, 4'b0100, 4'b0011, TRL, "R6 three cut, trailing majority");
        restart();
        t_learn(4'b0011, 4'b0000, 4'b0000, NON, "R6 exactly half cut");
        restart();
        t_learn(4'b1111, 4'b0000, 4'b0011, LED, "R6 tie goes leading");
    endtask

    // Filter counts down on a match; 3 up, 1 down, 1 up stays below threshold.
    task automatic t_filter_updown();
        t_vcheck(1'b1, 1'b0, VAL, LED, "R8 mismatch 1");
        t_vcheck(1'b1, 1'b0, VAL, LED, "R8 mismatch 2");
        t_vcheck(1'b1, 1'b0, VAL, LED, "R8 mismatch 3");
        t_vcheck(1'b0, 1'b0, VAL, LED, "R8 match decrements");
        t_vcheck(1'b1, 1'b0, VAL, LED, "R8 back to three");
        t_vcheck(1'b1, 1'b0, LRN, LED, "R9 threshold relearns");
    endtask

    // After relearn the filter starts from zero, and it saturates at zero on matches.
    task automatic t_filter_clear_sat();
        t_learn(4'b1111, 4'b1111, 4'b0000, LED, "R6 relearn leading");
        for (int k = 0; k < 3; k++) t_vcheck(1'b1, 1'b0, VAL, LED, "R9 cleared after relearn");
        for (int k = 0; k < 5; k++) t_vcheck(1'b0, 1'b0, VAL, LED, "R8 matches");
        for (int k = 0; k < 3; k++) t_vcheck(1'b1, 1'b0, VAL, LED, "R8 saturated at zero");
        t_vcheck(1'b1, 1'b0, LRN, LED, "R9 relearn after floor");
    endtask

    // Supply loss in the same cycle as the threshold compare, and as the last learn strobe.
    task automatic t_collisions();
        t_learn(4'b1111, 4'b1111, 4'b0000, LED, "R6 leading before collision");
        for (int k = 0; k < 3; k++) t_vcheck(1'b1, 1'b0, VAL, LED, "R8 build up");
        t_vcheck(1'b1, 1'b1, IDL, NON, "R2 loss beats relearn");
        pwr_ok = 1'b1;
        @(negedge clk);
        expect_st("R2 restart", LRN, LED);
        t_learn(4'b1111, 4'b1111, 4'b0000, LED, "R6 fresh learn");
        for (int k = 0; k < 3; k++) t_vcheck(1'b1, 1'b0, VAL, LED, "R9 filter cleared by idle");
        restart();
        for (int i = 0; i < 3; i++) hc(1'b1, 1'b1, 1'b0, 1'b1);
        hc(1'b1, 1'b1, 1'b0, 1'b0);
        expect_st("R2 loss beats learn end", IDL, NON);
        pwr_ok = 1'b1;
        @(negedge clk);
        expect_st("R2 restart 2", LRN, LED);
        t_learn(4'b1111, 4'b0000, 4'b1111, TRL, "R5 full window after loss");
        repeat (5) @(negedge clk);
        expect_st("R10 mode steady in validate", VAL, TRL);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_learn_patterns();
        t_filter_updown();
        t_filter_clear_sat();
        t_collisions();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule